// File: doc/BRIEF.md
# Coincident Edge Sync Pulse Generator

This block runs on one fast clock and produces two divided bank clocks, bank A and bank C. Each bank has its own divide ratio, chosen from a small set by a 2-bit select. The block also drives an active-low look-ahead marker, `sync_n`. The marker drops a fixed time before every fast-clock cycle in which both bank clocks rise together. It returns high in exactly that cycle. Downstream logic that moves data between the two bank domains can use it to find the next safe transfer point, including when one frequency is not an integer multiple of the other.

A shared divider reset, `div_rst`, aligns everything. While it is high, both bank clocks are low, the marker is high, and the selects are captured. The first fast-clock edge that samples `div_rst` low makes both banks rise together, which is a shared edge. After that, shared edges repeat every lcm(NA, NC) fast cycles. NA and NC are the captured ratios.

The marker is low for W fast cycles before each shared edge. W is the period of the faster bank clock, in fast cycles. When both banks have the same ratio, every edge is shared, and W is then half that period.

Top module: `coinc_sync_gen`

## Requirements
- R1: While running, `sync_n` is low in exactly the W fast cycles that come before each shared rising edge, and high everywhere else. W is min(NA, NC), except when NA equals NC.
- R2: `sync_n` goes from low to high only in the cycle where both bank clocks rise, or when a reset forces it high. In every shared-edge cycle it is high.
- R3: Bank A ratio NA by `sel_a`: 0 gives 4, 1 gives 6, 2 gives 8, 3 gives 12. Counting k fast cycles from release, the clock is high when (k mod NA) < NA/2.
- R4: Bank C ratio NC by `sel_c`: 0 gives 2, 1 gives 4, 2 gives 6, 3 gives 8. The clock is high when (k mod NC) < NC/2.
- R5: Shared edges recur every lcm(NA, NC) fast cycles. This includes non-integer pairs such as 3:2 and 4:3, and the marker fires before each of them.
- R6: When NA equals NC, every bank edge is shared, and the marker is low for NA/2 cycles before each edge.
- R7: While `div_rst` is sampled high, `bank_a_clk` and `bank_c_clk` are 0 and `sync_n` is 1. On the first edge that samples it low, both clocks rise, `sync_n` is 1, and k is 0.
- R8: A change of `sel_a` or `sel_c` while `div_rst` is low does not alter any output. The selects are captured only while `div_rst` is high.
- R9: `rst_n` low sets the outputs at once to 0, 0 and 1. Its release is synchronised to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| div_rst | input | 1 | Shared divider reset, active high, synchronous |
| sel_a | input | 2 | Bank A ratio select |
| sel_c | input | 2 | Bank C ratio select |
| bank_a_clk | output | 1 | Divided bank A clock, registered |
| bank_c_clk | output | 1 | Divided bank C clock, registered |
| sync_n | output | 1 | Active-low look-ahead marker for shared rising edges |

## Verification
The marker uses its own repeat counter rather than decoding the bank phases. A wrong counter limit or a wrong low-window threshold therefore shows up as a marker edge that does not line up with a joint rise of the two bank clocks. This appears within one repeat period, at most 24 fast cycles, after `div_rst` is released. A wrong captured ratio shows up on the bank clock itself within one bank period. A capture that leaks while the block is running changes the bank clock's period or the marker's timing within the next repeat period after the select change. The model in the bench counts cycles since release and is compared on every clock, so each of these errors is caught in the cycle where it first appears.

// File: rtl/csync_pkg.sv
package csync_pkg;

  function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
    int unsigned x;
    int unsigned y;
    int unsigned r;
    x = a;
    y = b;
    for (int i = 0; i < 32; i++) begin
      if (y != 0) begin
        r = x % y;
        x = y;
        y = r;
      end
    end
    return x;
  endfunction

  function automatic int unsigned lcm_u(input int unsigned a, input int unsigned b);
    return (a / gcd_u(a, b)) * b;
  endfunction

  // Low-window length: period of the faster bank, halved when both banks match.
  function automatic int unsigned win_u(input int unsigned a, input int unsigned b);
    int unsigned f;
    f = (a < b) ? a : b;
    return (lcm_u(a, b) == f) ? f / 2 : f;
  endfunction

endpackage

// File: rtl/csync_rst_sync.sv
module csync_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/csync_bank_div.sv
module csync_bank_div #(
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned PHASE_W = 5,
  parameter int unsigned RATIOS [2**SEL_W] = '{4, 6, 8, 12}
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             div_rst,
  input  logic [SEL_W-1:0] sel,
  output logic             bclk
);
  localparam int unsigned NSEL = 2**SEL_W;

  logic [PHASE_W-1:0] last_tab [NSEL];
  logic [PHASE_W-1:0] half_tab [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_tab
    assign last_tab[g] = PHASE_W'(RATIOS[g] - 1);
    assign half_tab[g] = PHASE_W'(RATIOS[g] / 2);
  end

  logic [PHASE_W-1:0] last_q, last_n;
  logic [PHASE_W-1:0] half_q, half_n;
  logic [PHASE_W-1:0] phase_q, phase_n;
  logic               bclk_q, bclk_n;
  logic               cap_en;

  assign cap_en = div_rst;

  always_comb begin
    last_n  = last_q;
    half_n  = half_q;
    phase_n = phase_q;
    bclk_n  = bclk_q;
    if (cap_en) begin
      last_n  = last_tab[sel];
      half_n  = half_tab[sel];
      phase_n = last_tab[sel];
      bclk_n  = 1'b0;
    end else begin
      phase_n = (phase_q == last_q) ? '0 : phase_q + 1'b1;
      bclk_n  = (phase_n < half_q);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      last_q  <= '0;
      half_q  <= '0;
      phase_q <= '0;
      bclk_q  <= 1'b0;
    end else begin
      last_q  <= last_n;
      half_q  <= half_n;
      phase_q <= phase_n;
      bclk_q  <= bclk_n;
    end
  end

  assign bclk = bclk_q;
endmodule

// File: rtl/csync_window.sv
module csync_window #(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned A_RATIOS [2**SEL_W] = '{4, 6, 8, 12},
  parameter int unsigned C_RATIOS [2**SEL_W] = '{2, 4, 6, 8}
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             div_rst,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_c,
  output logic             sync_n
);
  import csync_pkg::*;

  localparam int unsigned NSEL = 2**SEL_W;
  localparam int unsigned NPAIR = NSEL * NSEL;

  logic [CNT_W-1:0] last_tab [NPAIR];
  logic [CNT_W-1:0] thr_tab  [NPAIR];

  for (genvar ga = 0; ga < NSEL; ga++) begin : g_a
    for (genvar gc = 0; gc < NSEL; gc++) begin : g_c
      assign last_tab[ga*NSEL+gc] = CNT_W'(lcm_u(A_RATIOS[ga], C_RATIOS[gc]) - 1);
      assign thr_tab[ga*NSEL+gc]  = CNT_W'(lcm_u(A_RATIOS[ga], C_RATIOS[gc])
                                          - win_u(A_RATIOS[ga], C_RATIOS[gc]));
    end
  end

  logic [2*SEL_W-1:0] pair_idx;
  logic [CNT_W-1:0]   last_q, last_n;
  logic [CNT_W-1:0]   thr_q, thr_n;
  logic [CNT_W-1:0]   rep_q, rep_n;
  logic               sync_q, sync_nx;
  logic               cap_en;

  assign pair_idx = {sel_a, sel_c};
  assign cap_en   = div_rst;

  always_comb begin
    last_n  = last_q;
    thr_n   = thr_q;
    rep_n   = rep_q;
    sync_nx = sync_q;
    if (cap_en) begin
      last_n  = last_tab[pair_idx];
      thr_n   = thr_tab[pair_idx];
      rep_n   = last_tab[pair_idx];
      sync_nx = 1'b1;
    end else begin
      rep_n   = (rep_q == last_q) ? '0 : rep_q + 1'b1;
      sync_nx = (rep_n < thr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      last_q <= '0;
      thr_q  <= '0;
      rep_q  <= '0;
      sync_q <= 1'b1;
    end else begin
      last_q <= last_n;
      thr_q  <= thr_n;
      rep_q  <= rep_n;
      sync_q <= sync_nx;
    end
  end

  assign sync_n = sync_q;
endmodule

// File: rtl/coinc_sync_gen.sv
module coinc_sync_gen #(
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned PHASE_W = 5,
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned A_RATIOS [2**SEL_W] = '{4, 6, 8, 12},
  parameter int unsigned C_RATIOS [2**SEL_W] = '{2, 4, 6, 8}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_rst,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_c,
  output logic             bank_a_clk,
  output logic             bank_c_clk,
  output logic             sync_n
);
  logic rst_sn;

  csync_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  csync_bank_div #(
    .SEL_W(SEL_W), .PHASE_W(PHASE_W), .RATIOS(A_RATIOS)
  ) u_div_a (
    .clk(clk), .rst_sn(rst_sn), .div_rst(div_rst), .sel(sel_a), .bclk(bank_a_clk)
  );

  csync_bank_div #(
    .SEL_W(SEL_W), .PHASE_W(PHASE_W), .RATIOS(C_RATIOS)
  ) u_div_c (
    .clk(clk), .rst_sn(rst_sn), .div_rst(div_rst), .sel(sel_c), .bclk(bank_c_clk)
  );

  csync_window #(
    .SEL_W(SEL_W), .CNT_W(CNT_W), .A_RATIOS(A_RATIOS), .C_RATIOS(C_RATIOS)
  ) u_win (
    .clk(clk), .rst_sn(rst_sn), .div_rst(div_rst),
    .sel_a(sel_a), .sel_c(sel_c), .sync_n(sync_n)
  );
endmodule

// File: rtl/csync_chk.sv
module csync_chk #(
  parameter int unsigned MAX_LOW = 12
) (
  input logic clk,
  input logic rst_sn,
  input logic div_rst,
  input logic qa,
  input logic qc,
  input logic sync_n
);
  logic qa_d, qc_d, armed;
  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      qa_d    <= 1'b0;
      qc_d    <= 1'b0;
      armed   <= 1'b0;
      low_run <= 0;
    end else begin
      qa_d    <= qa;
      qc_d    <= qc;
      if (div_rst) armed <= 1'b0;
      else if (qa && !qa_d && qc && !qc_d) armed <= 1'b1;
      low_run <= sync_n ? 0 : low_run + 1;
    end
  end

  AST_SHARED_EDGE_HIGH: assert property (@(posedge clk) disable iff (!rst_sn)
    ($rose(qa) && $rose(qc)) |-> sync_n); // R2

  AST_RISE_ONLY_SHARED: assert property (@(posedge clk) disable iff (!rst_sn)
    ($rose(sync_n) && !$past(div_rst)) |-> ($rose(qa) && $rose(qc))); // R2

  AST_LOW_BEFORE_SHARED: assert property (@(posedge clk) disable iff (!rst_sn)
    (armed && $rose(qa) && $rose(qc)) |-> !$past(sync_n)); // R1

  AST_DIVRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(div_rst) |-> (sync_n && !qa && !qc)); // R7

  always_comb begin
    AST_LOW_BOUNDED: assert (low_run <= MAX_LOW); // R1
  end
endmodule

bind coinc_sync_gen csync_chk u_chk (
  .clk(clk), .rst_sn(rst_sn), .div_rst(div_rst),
  .qa(bank_a_clk), .qc(bank_c_clk), .sync_n(sync_n)
);

// File: tb/sim_coinc_sync_gen.sv
module sim_coinc_sync_gen;
  logic       clk;
  logic       rst_n;
  logic       div_rst;
  logic [1:0] sel_a;
  logic [1:0] sel_c;
  logic       bank_a_clk, bank_c_clk, sync_n;

  coinc_sync_gen u0 (
    .clk(clk), .rst_n(rst_n), .div_rst(div_rst), .sel_a(sel_a), .sel_c(sel_c),
    .bank_a_clk(bank_a_clk), .bank_c_clk(bank_c_clk), .sync_n(sync_n)
  );

  int    vecs = 0;
  int    errs = 0;
  string tag  = "R7";
  int    k    = -1;
  int    na   = 4;
  int    nc   = 2;
  int    ra [4] = '{4, 6, 8, 12};
  int    rc [4] = '{2, 4, 6, 8};

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int lcm_b(input int a, input int c);
    for (int m = a; m <= a * c; m += a)
      if (m % c == 0) return m;
    return a * c;
  endfunction

  function automatic int win_b(input int a, input int c);
    int f;
    f = (a < c) ? a : c;
    return (a == c) ? f / 2 : f;
  endfunction

  // Reference model: cycle count since release
  always @(posedge clk) begin
    logic ea, ec, es;
    int   l;
    if (!rst_n) k = -1;
    else if (div_rst) begin
      k  = -1;
      na = ra[sel_a];
      nc = rc[sel_c];
    end else k++;
    #5;
    l = lcm_b(na, nc);
    if (k < 0) begin
      ea = 1'b0; ec = 1'b0; es = 1'b1;
    end else begin
      ea = (k % na) < (na / 2);
      ec = (k % nc) < (nc / 2);
      es = (k % l) < (l - win_b(na, nc));
    end
    vecs++;
    if (bank_a_clk !== ea) begin
      errs++;
      $display("FAIL R3 bank_a_clk k=%0d got %0b exp %0b", k, bank_a_clk, ea);
    end
    if (bank_c_clk !== ec) begin
      errs++;
      $display("FAIL R4 bank_c_clk k=%0d got %0b exp %0b", k, bank_c_clk, ec);
    end
    if (sync_n !== es) begin
      errs++;
      $display("FAIL %s sync_n k=%0d got %0b exp %0b",
               (k >= 0 && k % l == 0) ? "R2" : tag, k, sync_n, es);
    end
  end

  task automatic run_pair(input int a, input int c);
    int l;
    l = lcm_b(ra[a], rc[c]);
    @(negedge clk);
    tag = "R7"; div_rst = 1'b1; sel_a = 2'(a); sel_c = 2'(c);
    repeat (3) @(negedge clk);
    if (ra[a] == rc[c])        tag = "R6";
    else if (l != ra[a] && l != rc[c]) tag = "R5";
    else                       tag = "R1";
    div_rst = 1'b0;
    repeat (2 * l + 4) @(negedge clk);
    tag = "R8";                  // selects move while running: no effect
    sel_a = ~sel_a; sel_c = sel_c + 2'd1;
    repeat (l + 4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; div_rst = 1'b1; sel_a = 2'd0; sel_c = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 4; a++)
      for (int c = 0; c < 4; c++)
        run_pair(a, c);
    // R7: divider reset asserted inside a low window
    run_pair(2, 2);
    tag = "R1";
    while (!(k >= 0 && (k % 24) == 22)) @(negedge clk);
    tag = "R7"; div_rst = 1'b1;
    repeat (2) @(negedge clk);
    div_rst = 1'b0; tag = "R5";
    repeat (30) @(negedge clk);
    // R9: asynchronous reset mid-run
    tag = "R9"; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    div_rst = 1'b1; sel_a = 2'd1; sel_c = 2'd2; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    div_rst = 1'b0; tag = "R5";
    repeat (30) @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired got running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule